// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins, two by default, and turns activity on them into interrupt requests. Each line has a 2-bit sense code in a shared 8-bit control register. The code selects one of four conditions: a low level, any change, a falling edge or a rising edge. Each pin passes through a synchroniser and then an edge-detect register, and every edge is found by comparing two successive samples.

In the three edge modes, a detected edge sets a pending flag for that line. Software clears the flag by writing 1 to it, and the interrupt controller clears it with a one-cycle acknowledge. In low-level mode nothing is latched: the request simply follows the synchronised pin. A line's request leaves the block only when the global enable and that line's mask bit are both set. Pins are sampled whatever their direction, so firmware that drives a pin itself can trigger an interrupt on purpose.

Top module: `eint_ctrl`

## Requirements
- R1: The 8-bit control register resets to 0x00. Every bit can be written through `ctl_wr_en`/`ctl_wr_data` and is read back on `ctl_rd_data` from the cycle after the write. It holds its value when no write occurs.
- R2: The sense code of line 0 sits in control bits 1:0 and that of line 1 in bits 3:2. In general, line i uses bits 2i+1:2i.
- R3: Sense code 00 is level mode. The line's request is high while the synchronised pin is low, and it drops two clocks after the pin goes high, with nothing remembered.
- R4: Sense code 01 sets the line's pending flag on any change of the synchronised pin.
- R5: Sense code 10 sets the pending flag on a falling edge only.
- R6: Sense code 11 sets the pending flag on a rising edge only.
- R7: A pin change sampled by a clock edge shows on `flag_rd` three clocks later. A pulse that is high for a single clock period still sets the flag in any-change mode.
- R8: `irq_req[i]` is high only when `glb_en` and `line_mask[i]` are both 1 and the line's condition holds: the pending flag in the edge modes, or the level request in level mode.
- R9: Writing with `flag_wr_en` clears each pending flag whose `flag_wr_data` bit is 1. A 0 bit leaves its flag unchanged.
- R10: A high `irq_ack[i]` for one cycle clears pending flag i.
- R11: If a new edge and a clear arrive in the same cycle, the flag ends up set.
- R12: If a control write changes a line's sense code in a cycle, an edge detected in that same cycle does not set that line's flag.
- R13: After reset, no edge is reported until the synchroniser and the previous-sample register hold real pin samples. A pin that is held high through reset never sets a flag.
- R14: Level mode never sets the pending flag, however the pin moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Control register write value |
| ctl_rd_data | output | 8 | Control register contents |
| flag_wr_en | input | 1 | Write strobe for the pending flags (write-1-to-clear) |
| flag_wr_data | input | NUM_LINES | Flags to clear |
| flag_rd | output | NUM_LINES | Pending flags |
| glb_en | input | 1 | Global interrupt enable |
| line_mask | input | NUM_LINES | Per-line enable |
| irq_ack | input | NUM_LINES | One-cycle acknowledge per line from the interrupt controller |
| ext_pin | input | NUM_LINES | Raw external pins |
| irq_req | output | NUM_LINES | Gated interrupt requests |

## Verification
The directed cases cover the points where a small slip changes behaviour. A pin held high through reset would show a false edge if the previous-sample register started at zero. A one-clock pulse would be missed if only one sample were compared. An edge arriving together with a clear would be lost if the clear won. An edge in the same cycle as a sense-code rewrite would leave a stale flag if the write did not suppress it. Further directed cases check that a level request drops once the pin is high, that a falling edge is ignored in rising mode, and that the sense codes are decoded at the right bit positions, since a swapped field would wake the wrong line. Seeded random pin, write, acknowledge and mask traffic then runs against a cycle model built in the bench.

// File: rtl/eint_pkg.sv
package eint_pkg;
   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_ANY  = 2'b01,
      SNS_FALL = 2'b10,
      SNS_RISE = 2'b11
   } sense_e;
   localparam int unsigned SNS_W = 2;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eint_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eint_arm.sv
module eint_arm #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic armed_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
   end

   assign armed_o = (cnt_q == LIM_C);

   p_arm_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o |=> armed_o);
endmodule

// File: rtl/eint_sense.sv
module eint_sense
   import eint_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   armed_i,
   input  logic   smp_i,
   input  sense_e sense_i,
   input  logic   fld_chg_i,
   input  logic   clr_i,
   output logic   pend_o,
   output logic   lvl_o
);
   logic prev_q;
   logic pend_q;
   logic hit;
   logic set_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp_i;
   end

   always_comb begin
      unique case (sense_i)
         SNS_ANY:  hit = smp_i ^ prev_q;
         SNS_FALL: hit = prev_q & ~smp_i;
         SNS_RISE: hit = smp_i & ~prev_q;
         default:  hit = 1'b0;
      endcase
   end

   assign set_pend = armed_i & hit & ~fld_chg_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (set_pend) pend_q <= 1'b1;
      else if (clr_i)    pend_q <= 1'b0;
   end

   assign pend_o = pend_q;
   assign lvl_o  = armed_i & (sense_i == SNS_LOW) & ~smp_i;

   p_level_no_pend_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i == SNS_LOW) |=> !$rose(pend_q));
   p_fld_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fld_chg_i |=> !$rose(pend_q));
   p_edge_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(smp_i != prev_q));
   p_fall_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && $past(sense_i) == SNS_FALL) |-> $past(prev_q && !smp_i));
   p_rise_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && $past(sense_i) == SNS_RISE) |-> $past(!prev_q && smp_i));
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && smp_i == prev_q) |=> !pend_q);
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && armed_i && !fld_chg_i && sense_i == SNS_ANY && smp_i != prev_q) |=> pend_q);
   p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_i && sense_i == SNS_LOW && !smp_i) |-> lvl_o);
   p_quiet_unarmed_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_i |-> (!pend_q && !lvl_o));
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
   import eint_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 2,
   parameter int unsigned CTRL_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_wr_en,
   input  logic [CTRL_W-1:0]    ctl_wr_data,
   output logic [CTRL_W-1:0]    ctl_rd_data,
   input  logic                 flag_wr_en,
   input  logic [NUM_LINES-1:0] flag_wr_data,
   output logic [NUM_LINES-1:0] flag_rd,
   input  logic                 glb_en,
   input  logic [NUM_LINES-1:0] line_mask,
   input  logic [NUM_LINES-1:0] irq_ack,
   input  logic [NUM_LINES-1:0] ext_pin,
   output logic [NUM_LINES-1:0] irq_req
);
   localparam int unsigned FLD_W   = SNS_W;
   localparam int unsigned ARM_LIM = SYNC_STAGES + 1;

   generate
      if (NUM_LINES * FLD_W > CTRL_W) begin : g_bad_width
         $error("eint_ctrl: sense fields do not fit in the control register");
      end
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("eint_ctrl: NUM_LINES must be at least 1");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl_q <= '0;
      else if (ctl_wr_en) ctrl_q <= ctl_wr_data;
   end

   assign ctl_rd_data = ctrl_q;

   eint_arm #(.LIMIT(ARM_LIM)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed_o (armed)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic   smp;
      logic   fld_chg;
      logic   clr;
      logic   pend;
      logic   lvl;
      sense_e sns;

      assign sns     = sense_e'(ctrl_q[FLD_W*i +: FLD_W]);
      assign fld_chg = ctl_wr_en & (ctl_wr_data[FLD_W*i +: FLD_W] != ctrl_q[FLD_W*i +: FLD_W]);
      assign clr     = (flag_wr_en & flag_wr_data[i]) | irq_ack[i];

      eint_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (ext_pin[i]),
         .q_o   (smp)
      );

      eint_sense u_sense (
         .clk       (clk),
         .rst_n     (rst_n),
         .armed_i   (armed),
         .smp_i     (smp),
         .sense_i   (sns),
         .fld_chg_i (fld_chg),
         .clr_i     (clr),
         .pend_o    (pend),
         .lvl_o     (lvl)
      );

      assign flag_rd[i] = pend;
      assign irq_req[i] = glb_en & line_mask[i] & ((sns == SNS_LOW) ? lvl : pend);

      p_req_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_req[i] && sns != SNS_LOW) |-> flag_rd[i]);
   end

   p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr_en |=> $stable(ctl_rd_data));
   p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en |=> (ctl_rd_data == $past(ctl_wr_data)));
endmodule

// File: tb/test_eint_ctrl.sv
module test_eint_ctrl;
   localparam int NL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr_en = 1'b0;
   logic [7:0]    ctl_wr_data = '0;
   logic [7:0]    ctl_rd_data;
   logic          flag_wr_en = 1'b0;
   logic [NL-1:0] flag_wr_data = '0;
   logic [NL-1:0] flag_rd;
   logic          glb_en = 1'b1;
   logic [NL-1:0] line_mask = '1;
   logic [NL-1:0] irq_ack = '0;
   logic [NL-1:0] ext_pin = '0;
   logic [NL-1:0] irq_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // model state
   logic [NL-1:0] m_s1, m_s2, m_p, m_pend;
   logic [7:0]    m_ctrl;
   int            m_cnt;

   always #2 clk = ~clk;

   eint_ctrl i_eint_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
      .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data), .flag_rd(flag_rd),
      .glb_en(glb_en), .line_mask(line_mask), .irq_ack(irq_ack),
      .ext_pin(ext_pin), .irq_req(irq_req)
   );

   function automatic logic [1:0] sns(input int i);
      return m_ctrl[2*i +: 2];
   endfunction

   function automatic logic [NL-1:0] exp_req();
      logic [NL-1:0] r;
      for (int i = 0; i < NL; i++) begin
         logic lvl;
         lvl  = (m_cnt >= 3) && sns(i) == 2'b00 && !m_s2[i];
         r[i] = glb_en && line_mask[i] && ((sns(i) == 2'b00) ? lvl : m_pend[i]);
      end
      return r;
   endfunction

   function automatic logic [NL-1:0] next_pend();
      logic [NL-1:0] n;
      for (int i = 0; i < NL; i++) begin
         logic hit, chg, clr;
         case (sns(i))
            2'b01:   hit = m_s2[i] ^ m_p[i];
            2'b10:   hit = m_p[i] & ~m_s2[i];
            2'b11:   hit = m_s2[i] & ~m_p[i];
            default: hit = 1'b0;
         endcase
         chg  = ctl_wr_en && (ctl_wr_data[2*i +: 2] != m_ctrl[2*i +: 2]);
         clr  = (flag_wr_en && flag_wr_data[i]) || irq_ack[i];
         n[i] = ((m_cnt >= 3) && hit && !chg) || (m_pend[i] && !clr);
      end
      return n;
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk({tag, " ctrl"}, ctl_rd_data, m_ctrl);
      chk({tag, " flag"}, 8'(flag_rd), 8'(m_pend));
      chk({tag, " req"},  8'(irq_req), 8'(exp_req()));
   endtask

   task automatic step(input string tag);
      logic [NL-1:0] np;
      logic [7:0]    nc;
      np = next_pend();
      nc = ctl_wr_en ? ctl_wr_data : m_ctrl;
      @(posedge clk);
      m_p    = m_s2;
      m_s2   = m_s1;
      m_s1   = ext_pin;
      m_pend = np;
      m_ctrl = nc;
      if (m_cnt < 3) m_cnt++;
      @(negedge clk);
      compare(tag);
      ctl_wr_en  = 1'b0;
      flag_wr_en = 1'b0;
      irq_ack    = '0;
   endtask

   task automatic steps(input int n, input string tag);
      for (int k = 0; k < n; k++) step(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_s1 = '0; m_s2 = '0; m_p = '0; m_pend = '0; m_ctrl = '0; m_cnt = 0;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
   endtask

   task automatic wr_ctrl(input logic [7:0] v, input string tag);
      ctl_wr_en = 1'b1; ctl_wr_data = v;
      step(tag);
   endtask

   task automatic w1c(input logic [NL-1:0] v, input string tag);
      flag_wr_en = 1'b1; flag_wr_data = v;
      step(tag);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      @(negedge clk);
      // R13: pins high through reset, any-change mode written straight away
      ext_pin = 2'b11;
      do_reset();
      wr_ctrl(8'h05, "R13 arm");
      steps(5, "R13 hold");
      chk("R13 no false edge", 8'(flag_rd), 8'h00);

      // R1: full register read back
      wr_ctrl(8'hA5, "R1 write");
      chk("R1 readback", ctl_rd_data, 8'hA5);

      // R2 R3 R6: line1 rising, line0 level
      wr_ctrl(8'h0C, "R2 cfg");
      steps(2, "R2 settle");
      ext_pin = 2'b00;
      steps(2, "R3 fall");
      chk("R3 level asserted", 8'(irq_req), 8'h01);
      steps(2, "R6 wait");
      chk("R6 falling ignored", 8'(flag_rd), 8'h00);
      ext_pin = 2'b10;
      steps(3, "R7 latency");
      chk("R2 R6 line1 rise flag", 8'(flag_rd), 8'h02);
      ext_pin = 2'b11;
      steps(2, "R3 rise");
      chk("R3 level released", 8'(irq_req), 8'h02);

      // R9 write-1-to-clear
      w1c(2'b01, "R9 zero bit");
      chk("R9 zero keeps", 8'(flag_rd), 8'h02);
      w1c(2'b10, "R9 one bit");
      chk("R9 one clears", 8'(flag_rd), 8'h00);

      // R5 R10 falling mode, acknowledge
      wr_ctrl(8'h08, "R5 cfg");
      ext_pin = 2'b01;
      steps(3, "R5 fall");
      chk("R5 falling sets", 8'(flag_rd), 8'h02);
      irq_ack = 2'b10;
      step("R10 ack");
      chk("R10 ack clears", 8'(flag_rd), 8'h00);

      // R7 single-clock pulse in any-change mode
      wr_ctrl(8'h04, "R7 cfg");
      steps(2, "R7 idle");
      ext_pin = 2'b11;
      step("R7 pulse");
      ext_pin = 2'b01;
      steps(4, "R7 after");
      chk("R7 short pulse caught", 8'(flag_rd), 8'h02);
      w1c(2'b10, "R7 clear");

      // R11 set beats clear
      ext_pin = 2'b11;
      steps(2, "R11 sync");
      flag_wr_en = 1'b1; flag_wr_data = 2'b10;
      step("R11 both");
      chk("R11 set wins", 8'(flag_rd), 8'h02);
      w1c(2'b10, "R11 clear");
      steps(2, "R11 idle");

      // R12 field rewrite in the edge cycle
      ext_pin = 2'b01;
      steps(2, "R12 sync");
      wr_ctrl(8'h0C, "R12 rewrite");
      steps(2, "R12 after");
      chk("R12 no stale flag", 8'(flag_rd), 8'h00);

      // R14 level mode toggling
      wr_ctrl(8'h00, "R14 cfg");
      for (int k = 0; k < 6; k++) begin
         ext_pin = ext_pin ^ 2'b11;
         steps(2, "R14 toggle");
      end
      steps(3, "R14 settle");
      chk("R14 no flag", 8'(flag_rd), 8'h00);

      // R8 gating
      wr_ctrl(8'h05, "R8 cfg");
      ext_pin = ext_pin ^ 2'b01;
      glb_en = 1'b0;
      steps(3, "R8 edge");
      chk("R8 global off", 8'(irq_req), 8'h00);
      glb_en = 1'b1; line_mask = 2'b00;
      step("R8 mask off");
      chk("R8 mask off", 8'(irq_req), 8'h00);
      line_mask = 2'b01;
      step("R8 mask on");
      chk("R8 mask on", 8'(irq_req), 8'h01);

      // random traffic, R4 R5 R6 R8 R9 R10 R11 R12
      for (int k = 0; k < 3000; k++) begin
         if ($urandom_range(2) == 0) ext_pin = 2'($urandom);
         if ($urandom_range(15) == 0) begin ctl_wr_en = 1'b1; ctl_wr_data = 8'($urandom); end
         if ($urandom_range(7) == 0) begin flag_wr_en = 1'b1; flag_wr_data = 2'($urandom); end
         if ($urandom_range(7) == 0) irq_ack = 2'($urandom);
         if ($urandom_range(31) == 0) line_mask = 2'($urandom);
         glb_en = ($urandom_range(9) != 0);
         step("R4 R8 random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule